// File: doc/BRIEF.md
# Display PHY Test-Port Access Bridge

This block turns single register read and write requests into the strobe sequence that a display PHY's serial test port expects. The test port has five pins: a clear line, a strobe clock, an enable that marks an address cycle, an 8-bit input bus to the PHY and an 8-bit output bus from it. A write takes two strobes. In the first, the enable is high and the bus carries the register address. In the second, the enable is low and the bus carries the data. A read takes only the address strobe, then waits a programmable settle time and samples the PHY output bus. A third request kind pulses the clear line to reset the PHY test logic.

The request side uses a one-cycle `req` strobe. It carries an operation kind, an address and write data, both of which are wider than the port so that out-of-range values can be refused. Completion is signalled by a single-cycle `ack` carrying `err` and `rdata`. A prescaler input sets how many system clocks each strobe level lasts. A second input sets the read settle time in system clocks.

Top module: `phy_tport_bridge`

## Requirements
- R1: After reset the outputs `tp_clr`, `tp_clk`, `tp_en`, `ack` and `busy` are low.
- R2: A write or read starts with an address step in three equal segments, with `tp_en` high and `tp_din` carrying the address. `tp_clk` is low in the first segment, high in the second and low in the third. `tp_en` falls after the third segment.
- R3: A write continues with a data step with `tp_en` low. `tp_din` carries the write data, and `tp_clk` goes low, high, low in three equal segments. `ack` arrives on the (6P+1)-th clock edge counted from the edge that accepted the request, where P = `half_div`+1.
- R4: A read performs only the address step. It then holds every strobe low for `settle`+1 cycles and captures `tp_dout` at the end of the last of them. `rdata` holds that value while `ack` is high, on edge 3P+`settle`+2.
- R5: Every high level of `tp_clk` and of `tp_clr` lasts exactly P system clocks, and `tp_din` does not change while `tp_clk` is high.
- R6: A clear request (`req_clr`=1) drives `tp_clr` low, high, low for P cycles each, leaves `tp_clk` and `tp_en` low, and acks on edge 3P+1.
- R7: A read whose address exceeds 255, or a write whose address or data exceeds 255, is refused. It raises `ack` with `err`=1 on the accepting edge and produces no strobe, so PHY registers are untouched.
- R8: `ack` is high for exactly one cycle per accepted request, and `err` is 0 for every request that is carried out.
- R9: A request seen while `busy` is high, including in the ack cycle, is ignored. A request held high through a whole transfer yields a single transfer.
- R10: When `req_clr` and `req_wr` are both set, the clear is performed and no register write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_clr | input | 1 | 1 = clear pulse; has priority over `req_wr` |
| req_addr | input | REQ_W (12) | Register address; values above 255 are refused |
| req_wdata | input | REQ_W (12) | Write data; values above 255 are refused |
| half_div | input | DIV_W (8) | Strobe segment length minus one, in clocks |
| settle | input | SET_W (12) | Read settle length minus one, in clocks |
| ack | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request was refused (valid with `ack`) |
| rdata | output | PW (8) | Read result (valid with `ack`) |
| busy | output | 1 | A request is in progress |
| tp_clr | output | 1 | PHY test-logic clear |
| tp_clk | output | 1 | PHY test strobe clock |
| tp_en | output | 1 | PHY address-cycle enable |
| tp_din | output | PW (8) | Address or data to PHY |
| tp_dout | input | PW (8) | Data from PHY |

## Verification
Two situations can arise in the same cycle. First, a new request can coincide with the ack of the previous one. The bench keeps `req` high across a whole write and changes the address mid-flight. It counts `tp_clk` rising edges and checks that only the first address was written in the PHY model. Second, a clear and a write can be requested together. The bench raises both flags at once and judges the result by the latency, the clear-pulse count and an unchanged PHY register. The PHY model returns inverted data until the settle window has elapsed, so a capture that is one cycle early shows up as a data mismatch.

// File: rtl/phy_tport_bridge.sv
module phy_tport_bridge #(
  parameter int REQ_W = 12,
  parameter int PW    = 8,
  parameter int DIV_W = 8,
  parameter int SET_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             req_clr,
  input  logic [REQ_W-1:0] req_addr,
  input  logic [REQ_W-1:0] req_wdata,
  input  logic [DIV_W-1:0] half_div,
  input  logic [SET_W-1:0] settle,
  output logic             ack,
  output logic             err,
  output logic [PW-1:0]    rdata,
  output logic             busy,
  output logic             tp_clr,
  output logic             tp_clk,
  output logic             tp_en,
  output logic [PW-1:0]    tp_din,
  input  logic [PW-1:0]    tp_dout
);
  localparam int TW = (DIV_W > SET_W) ? DIV_W : SET_W;

  typedef enum logic [3:0] {
    S_IDLE, S_ASET, S_AHI, S_ALO, S_DSET, S_DHI, S_DLO,
    S_WAIT, S_CPRE, S_CHI, S_CPOST, S_DONE
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] din_q, dat_q;
  logic          wr_q;

  wire addr_big = |req_addr[REQ_W-1:PW];
  wire data_big = |req_wdata[REQ_W-1:PW];
  wire seg_end  = (tmr == '0);
  wire [TW-1:0] seg_len = TW'(half_div);

  assign ack    = (st == S_DONE);
  assign busy   = (st != S_IDLE);
  assign tp_en  = (st == S_ASET) || (st == S_AHI) || (st == S_ALO);
  assign tp_clk = (st == S_AHI) || (st == S_DHI);
  assign tp_clr = (st == S_CHI);
  assign tp_din = din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tmr   <= '0;
      din_q <= '0;
      dat_q <= '0;
      wr_q  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          tmr <= seg_len;
          if (req_clr) begin
            err <= 1'b0;
            st  <= S_CPRE;
          end else if (addr_big || (req_wr && data_big)) begin
            err <= 1'b1;
            st  <= S_DONE;
          end else begin
            err   <= 1'b0;
            wr_q  <= req_wr;
            din_q <= req_addr[PW-1:0];
            dat_q <= req_wdata[PW-1:0];
            st    <= S_ASET;
          end
        end
        S_ASET: if (seg_end) begin tmr <= seg_len; st <= S_AHI; end
                else tmr <= tmr - 1'b1;
        S_AHI:  if (seg_end) begin tmr <= seg_len; st <= S_ALO; end
                else tmr <= tmr - 1'b1;
        S_ALO:  if (seg_end) begin
                  if (wr_q) begin
                    tmr   <= seg_len;
                    din_q <= dat_q;
                    st    <= S_DSET;
                  end else begin
                    tmr <= TW'(settle);
                    st  <= S_WAIT;
                  end
                end else tmr <= tmr - 1'b1;
        S_DSET: if (seg_end) begin tmr <= seg_len; st <= S_DHI; end
                else tmr <= tmr - 1'b1;
        S_DHI:  if (seg_end) begin tmr <= seg_len; st <= S_DLO; end
                else tmr <= tmr - 1'b1;
        S_DLO:  if (seg_end) st <= S_DONE;
                else tmr <= tmr - 1'b1;
        S_WAIT: if (seg_end) begin rdata <= tp_dout; st <= S_DONE; end
                else tmr <= tmr - 1'b1;
        S_CPRE: if (seg_end) begin tmr <= seg_len; st <= S_CHI; end
                else tmr <= tmr - 1'b1;
        S_CHI:  if (seg_end) begin tmr <= seg_len; st <= S_CPOST; end
                else tmr <= tmr - 1'b1;
        S_CPOST: if (seg_end) st <= S_DONE;
                 else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_clk && $past(tp_clk)) |-> $stable(tp_din));

  // R2
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tp_en) |-> !tp_clk && !$past(tp_clk));

  // R7
  reject_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err) |-> !$past(busy));

  // R6
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_clr) |-> !$past(tp_en) && !$past(tp_clk));
endmodule

// File: tb/phy_tport_bridge_tb_top.sv
module phy_tport_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0, req_clr = 0;
  logic [11:0] req_addr = 0, req_wdata = 0;
  logic [7:0]  half_div = 0;
  logic [11:0] settle = 0;
  logic ack, err, busy, tp_clr, tp_clk, tp_en;
  logic [7:0] rdata, tp_din, tp_dout;

  int checks = 0, errors = 0;
  int p_len = 1;

  always #5 clk = ~clk;

  phy_tport_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_clr(req_clr),
    .req_addr(req_addr), .req_wdata(req_wdata), .half_div(half_div),
    .settle(settle), .ack(ack), .err(err), .rdata(rdata), .busy(busy),
    .tp_clr(tp_clr), .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din),
    .tp_dout(tp_dout));

  logic [7:0] mem [256];
  logic [7:0] m_addr = 0;
  int lo_cnt = 0;
  int clk_rises = 0, clr_rises = 0, wbad = 0, hi_c = 0, chi_c = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge tp_clk) begin
    if (tp_en) m_addr <= tp_din;
    else mem[m_addr] <= tp_din;
  end

  assign tp_dout = (lo_cnt > int'(settle)) ? mem[m_addr] : ~mem[m_addr];

  always @(negedge clk) begin
    if (tp_en) lo_cnt = 0;
    else if (lo_cnt < 100000) lo_cnt = lo_cnt + 1;
    if (tp_clk) begin
      if (hi_c == 0) clk_rises++;
      hi_c++;
    end else if (hi_c != 0) begin
      if (hi_c != p_len) wbad++;
      hi_c = 0;
    end
    if (tp_clr) begin
      if (chi_c == 0) clr_rises++;
      chi_c++;
    end else if (chi_c != 0) begin
      if (chi_c != p_len) wbad++;
      chi_c = 0;
    end
  end

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run(input bit w, input bit c, input int a, input int d,
                     output int lat, output int rd, output int e);
    @(negedge clk);
    req = 1; req_wr = w; req_clr = c; req_addr = 12'(a); req_wdata = 12'(d);
    @(negedge clk);
    req = 0; lat = 1;
    while (!ack && lat < 2000) begin @(negedge clk); lat++; end
    rd = int'(rdata); e = int'(err);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int n = 0; n < 190000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat, rd, e, r0, c0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 tp_clk", tp_clk, 0); check("R1 tp_en", tp_en, 0);
    check("R1 tp_clr", tp_clr, 0); check("R1 ack", ack, 0);
    check("R1 busy", busy, 0);
    rst_n = 1;

    for (int p = 0; p < 3; p++) begin
      half_div = 8'(p); settle = 12'(2 * p + 1); p_len = p + 1;
      for (int a = 0; a < 256; a++) begin
        run(1, 0, a, (a * 7 + p * 13) & 255, lat, rd, e);
        // R3 R8
        check("R3 write latency", lat, 6 * p_len + 1);
        check("R8 write err", e, 0);
        // R2
        check("R2 model write", mem[a], (a * 7 + p * 13) & 255);
      end
      for (int a = 0; a < 256; a++) begin
        run(0, 0, a, 0, lat, rd, e);
        // R4
        check("R4 read latency", lat, 3 * p_len + int'(settle) + 2);
        check("R4 read data", rd, (a * 7 + p * 13) & 255);
      end
      // R5
      check("R5 pulse width", wbad, 0);
    end

    half_div = 1; settle = 4; p_len = 2;
    // R7
    r0 = clk_rises;
    run(1, 0, 12'h100, 5, lat, rd, e);
    check("R7 big addr err", e, 1); check("R7 big addr lat", lat, 1);
    run(1, 0, 3, 12'h1FF, lat, rd, e);
    check("R7 big data err", e, 1);
    check("R7 mem kept", mem[3], (3 * 7 + 2 * 13) & 255);
    run(0, 0, 12'h3FF, 0, lat, rd, e);
    check("R7 big read err", e, 1);
    check("R7 no strobes", clk_rises, r0);
    run(0, 0, 7, 12'hFFF, lat, rd, e);
    check("R7 read ignores data range", e, 0);

    // R6
    c0 = clr_rises; r0 = clk_rises;
    run(0, 1, 0, 0, lat, rd, e);
    check("R6 clr latency", lat, 3 * p_len + 1);
    check("R6 clr pulses", clr_rises, c0 + 1);
    check("R6 no tp_clk", clk_rises, r0);
    check("R6 clr err", e, 0);

    // R10
    c0 = clr_rises;
    run(1, 1, 8'h20, 8'h99, lat, rd, e);
    check("R10 clr wins lat", lat, 3 * p_len + 1);
    check("R10 clr pulse", clr_rises, c0 + 1);
    check("R10 no write", mem[8'h20], (8'h20 * 7 + 2 * 13) & 255);

    // R9: req held through whole transfer and its ack cycle
    r0 = clk_rises;
    @(negedge clk);
    req = 1; req_wr = 1; req_clr = 0; req_addr = 5; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 6; req_wdata = 8'h22; lat = 1;
    while (!ack && lat < 2000) begin @(negedge clk); lat++; end
    req = 0;
    check("R9 latency", lat, 6 * p_len + 1);
    @(negedge clk);
    check("R9 idle after ack", busy, 0);
    check("R9 one transfer", clk_rises, r0 + 2);
    check("R9 first addr", mem[5], 8'h11);
    check("R9 second ignored", mem[6], (6 * 7 + 2 * 13) & 255);
    check("R8 ack dropped", ack, 0);
    check("R5 final widths", wbad, 0);
    finish_run();
  end
endmodule